// File: doc/BRIEF.md
# Single-Channel Programmable Pulse-Width Modulator

This block turns a module clock into one pulse-width modulated output whose shape is set by software through two 32-bit registers on a plain valid/write/address/data port. A prescaler turns the clock into a counting tick. A period counter then counts ticks across each period, and the output sits at its active level for the first part of every period. The active level can be set high or low.

The channel runs either continuously or as a single pulse on request. It produces output only while both its enable bit and its clock-gate bit are set. A period update is double-buffered: software writes new timing, a busy flag rises, and the running waveform takes the new values at the next period boundary. If the channel is stopped, it takes them on the next clock. Reads take one cycle and are combinational from the registers.

Top module: `pwm_chan_gen`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0 and `pwm_out` is 1, which is the inactive level of the default active-low polarity.
- R2: The control word sits at byte offset 0x00 and the timing word at 0x04. Control bits are: busy 28 (read-only), bypass 9, pulse start 8, pulse mode 7, clock gate 6, active-high 5, enable 4, prescaler select 3:0. Every other bit reads 0, and any other offset reads 0.
- R3: Timing word bits 31:16 hold the ticks per period minus one, and bits 15:0 hold the number of active ticks. In every period the output is active during the first `active` ticks and inactive for the rest.
- R4: A tick lasts 120 clocks for select code 0, 2^n clocks for select code n from 1 to 15, and one clock when bypass is set.
- R5: With active-high set to 1 the active level is 1. With it set to 0 the active level is 0.
- R6: Unless enable and clock gate are both 1, the output holds the inactive level and the counters rest at zero. A period starts on the clock edge that completes the enabling write.
- R7: A write to the timing word while idle sets busy. While the channel runs, the new values apply from the next period boundary, where busy clears.
- R8: A write to the timing word while busy is ignored.
- R9: While the channel is not counting, a pending timing word is taken on the next clock and busy clears one cycle after the write.
- R10: In pulse mode (mode bit 1), setting pulse start emits exactly one period. Then pulse start reads 0 and the output returns to inactive.
- R11: When the active ticks are at least the period length, the output stays active all period. When the active ticks are 0, it stays inactive.
- R12: In pulse mode with pulse start at 0, the output stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is compared clock by clock against a bench model. The model is driven by directed settings (tick length 120, full and zero duty, both polarities) and by seeded random mixes of period length, duty, prescaler code and bypass. The random runs separate faults in the prescaler from faults in the period counter and in the polarity. Separate runs cover the busy flag, the rejected second write and the switch-over at the exact boundary cycle. Single pulses, and the gating combinations that must stay idle, show whether start, self-clear and run-enable are wired apart correctly.

// File: rtl/pwm_chan_pkg.sv
// Shared field positions, control type and divisor function for the PWM channel.
// Assumes 32-bit registers whose bit positions are fixed by the software view.
package pwm_chan_pkg;
    localparam int REG_W    = 32;
    localparam int FIELD_W  = 16;
    localparam int SEL_W    = 4;
    localparam int CTL_RDY  = 28;
    localparam int CTL_BYP  = 9;
    localparam int CTL_GO   = 8;
    localparam int CTL_MODE = 7;
    localparam int CTL_GATE = 6;
    localparam int CTL_ACT  = 5;
    localparam int CTL_EN   = 4;

    typedef struct packed {
        logic             bypass;
        logic             pulse_go;
        logic             pulse_mode;
        logic             gate;
        logic             act_high;
        logic             enable;
        logic [SEL_W-1:0] psel;
    } ctl_t;

    // Clocks per tick for a select code; code 0 uses the special divisor.
    function automatic int unsigned psc_divisor(logic [SEL_W-1:0] code, int unsigned div_zero);
        if (code == '0) return div_zero;
        return 32'd1 << code;
    endfunction
endpackage

// File: rtl/pwm_chan_regs.sv
// Control word, pending and current timing words, and the busy flag.
// Assumes write strobes are already decoded; a timing write is accepted only when not busy.
module pwm_chan_regs
    import pwm_chan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctl,
    input  logic               wr_per,
    input  logic [REG_W-1:0]   wdata,
    input  logic               run,
    input  logic               boundary,
    output ctl_t               ctl,
    output logic               rdy,
    output logic [FIELD_W-1:0] pend_tot_m1,
    output logic [FIELD_W-1:0] pend_act,
    output logic [FIELD_W-1:0] cur_tot_m1,
    output logic [FIELD_W-1:0] cur_act
);
    // Control word: bus writes, plus pulse start self-clear at a pulse-mode boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (boundary && ctl.pulse_mode) ctl.pulse_go <= 1'b0;
            if (wr_ctl) begin
                ctl <= '{bypass:     wdata[CTL_BYP],
                         pulse_go:   wdata[CTL_GO],
                         pulse_mode: wdata[CTL_MODE],
                         gate:       wdata[CTL_GATE],
                         act_high:   wdata[CTL_ACT],
                         enable:     wdata[CTL_EN],
                         psel:       wdata[SEL_W-1:0]};
            end
        end
    end

    // Pending timing word and busy flag; transfer to current at boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy         <= 1'b0;
            pend_tot_m1 <= '0;
            pend_act    <= '0;
            cur_tot_m1  <= '0;
            cur_act     <= '0;
        end else if (wr_per && !rdy) begin
            rdy         <= 1'b1;
            pend_tot_m1 <= wdata[REG_W-1:FIELD_W];
            pend_act    <= wdata[FIELD_W-1:0];
        end else if (rdy && (boundary || !run)) begin
            rdy        <= 1'b0;
            cur_tot_m1 <= pend_tot_m1;
            cur_act    <= pend_act;
        end
    end
endmodule

// File: rtl/pwm_chan_psc.sv
// Prescaler: emits a one-cycle tick every N clocks while running.
// Assumes the largest divisor minus one fits in PSC_W bits; counter rests at zero when idle.
module pwm_chan_psc
    import pwm_chan_pkg::*;
#(
    parameter int PSC_W    = 16,
    parameter int DIV_ZERO = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             bypass,
    input  logic [SEL_W-1:0] psel,
    output logic             tick
);
    logic [PSC_W-1:0] div_m1;
    logic [PSC_W-1:0] cnt;

    // Terminal count from the selected divisor.
    always_comb div_m1 = PSC_W'(psc_divisor(psel, DIV_ZERO) - 1);

    // Tick on terminal count, or every cycle with bypass.
    always_comb tick = run && (bypass || (cnt == div_m1));

    // Clock counter inside one tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_chan_wave.sv
// Period counter and output shaping.
// Assumes timing inputs change only at a boundary or while idle.
module pwm_chan_wave
    import pwm_chan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic [FIELD_W-1:0] tot_m1,
    input  logic [FIELD_W-1:0] act,
    input  logic               act_high,
    output logic               boundary,
    output logic               pwm_out
);
    logic [FIELD_W-1:0] cnt;
    logic               active;

    // Last tick of a period closes it.
    always_comb boundary = run && tick && (cnt == tot_m1);

    // Active during the first act ticks of a period.
    always_comb active = run && (cnt < act);

    // Drive the programmed level.
    always_comb pwm_out = active ? act_high : !act_high;

    // Tick counter inside one period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || boundary) cnt <= '0;
        else if (tick)                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_chan_gen.sv
// Top of the single-channel PWM: bus decode, readback, run control.
// Assumes byte addressing with word offsets 0x00 and 0x04; reads are combinational.
module pwm_chan_gen
    import pwm_chan_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int PSC_W    = 16,
    parameter int DIV_ZERO = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              pwm_out
);
    localparam int WORD_W = ADDR_W - 2;

    ctl_t               ctl;
    logic               rdy, run, tick, boundary;
    logic               sel_ctl, sel_per, wr_ctl, wr_per;
    logic [FIELD_W-1:0] pend_tot_m1, pend_act, cur_tot_m1, cur_act;
    logic [REG_W-1:0]   rd_ctl;

    // Word decode of the two registers.
    always_comb begin
        sel_ctl = (bus_addr[ADDR_W-1:2] == WORD_W'(0)) && (bus_addr[1:0] == 2'b00);
        sel_per = (bus_addr[ADDR_W-1:2] == WORD_W'(1)) && (bus_addr[1:0] == 2'b00);
        wr_ctl  = bus_valid && bus_write && sel_ctl;
        wr_per  = bus_valid && bus_write && sel_per;
    end

    // Counting allowed only when enabled, gated, and (continuous or pulse requested).
    always_comb run = ctl.enable && ctl.gate && (!ctl.pulse_mode || ctl.pulse_go);

    // Control readback assembly.
    always_comb begin
        rd_ctl              = '0;
        rd_ctl[CTL_RDY]     = rdy;
        rd_ctl[CTL_BYP]     = ctl.bypass;
        rd_ctl[CTL_GO]      = ctl.pulse_go;
        rd_ctl[CTL_MODE]    = ctl.pulse_mode;
        rd_ctl[CTL_GATE]    = ctl.gate;
        rd_ctl[CTL_ACT]     = ctl.act_high;
        rd_ctl[CTL_EN]      = ctl.enable;
        rd_ctl[SEL_W-1:0]   = ctl.psel;
    end

    // Read data multiplexer.
    always_comb begin
        if (sel_ctl)      bus_rdata = rd_ctl;
        else if (sel_per) bus_rdata = {pend_tot_m1, pend_act};
        else              bus_rdata = '0;
    end

    pwm_chan_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctl      (wr_ctl),
        .wr_per      (wr_per),
        .wdata       (bus_wdata),
        .run         (run),
        .boundary    (boundary),
        .ctl         (ctl),
        .rdy         (rdy),
        .pend_tot_m1 (pend_tot_m1),
        .pend_act    (pend_act),
        .cur_tot_m1  (cur_tot_m1),
        .cur_act     (cur_act)
    );

    pwm_chan_psc #(.PSC_W(PSC_W), .DIV_ZERO(DIV_ZERO)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .bypass (ctl.bypass),
        .psel   (ctl.psel),
        .tick   (tick)
    );

    pwm_chan_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .tot_m1   (cur_tot_m1),
        .act      (cur_act),
        .act_high (ctl.act_high),
        .boundary (boundary),
        .pwm_out  (pwm_out)
    );
endmodule

// File: rtl/pwm_chan_gen_chk.sv
// Property checker bound to the PWM top; observes ports and internal nets only.
module pwm_chan_gen_chk
    import pwm_chan_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_ctl,
    input logic               wr_per,
    input logic               rdy,
    input logic               run,
    input logic               boundary,
    input logic               en,
    input logic               gate,
    input logic               mode,
    input logic               go,
    input logic               act_high,
    input logic [FIELD_W-1:0] pend_tot_m1,
    input logic [FIELD_W-1:0] pend_act,
    input logic [FIELD_W-1:0] cur_act,
    input logic               pwm_out
);
    AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && gate) |-> (pwm_out == !act_high)); // R6
    AST_RDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_per && !rdy) |=> rdy); // R7
    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && run && !boundary) |=> rdy); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_per && rdy) |=> ($stable(pend_tot_m1) && $stable(pend_act))); // R8
    AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !go) |-> (pwm_out == !act_high)); // R12
    AST_PULSE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && mode && !wr_ctl) |=> !go); // R10
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_act == '0) |-> (pwm_out == !act_high)); // R11
endmodule

bind pwm_chan_gen pwm_chan_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctl      (wr_ctl),
    .wr_per      (wr_per),
    .rdy         (rdy),
    .run         (run),
    .boundary    (boundary),
    .en          (ctl.enable),
    .gate        (ctl.gate),
    .mode        (ctl.pulse_mode),
    .go          (ctl.pulse_go),
    .act_high    (ctl.act_high),
    .pend_tot_m1 (pend_tot_m1),
    .pend_act    (pend_act),
    .cur_act     (cur_act),
    .pwm_out     (pwm_out)
);

// File: tb/test_pwm_chan_gen.sv
// Bench for pwm_chan_gen: directed corners plus seeded random waveform runs.
module test_pwm_chan_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;
    int tcnt   = 0;
    int base   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) tcnt <= tcnt + 1;

    pwm_chan_gen i_pwm_chan_gen (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    function automatic int exp_div(int code, bit byp);
        if (byp) return 1;
        if (code == 0) return 120;
        return 1 << code;
    endfunction

    function automatic bit exp_out(int t, int d, int tot, int act, bit pol, bit pulse);
        int ph;
        bit on;
        ph = t / d;
        if (pulse && ph >= tot) on = 1'b0;
        else on = ((ph % tot) < act);
        return on ? pol : !pol;
    endfunction

    function automatic logic [31:0] mk_ctl(bit byp, bit go, bit mode, bit gate, bit pol, bit en, int code);
        logic [31:0] w;
        w = '0;
        w[9] = byp; w[8] = go; w[7] = mode; w[6] = gate; w[5] = pol; w[4] = en;
        w[3:0] = 4'(code);
        return w;
    endfunction

    task automatic check(bit ok, string rq, string what, longint actual, longint expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, actual, expected);
        end
    endtask

    task automatic bus_wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // Program a timing word while stopped, start, and compare every clock.
    task automatic run_wave(int tot_m1, int act, int code, bit byp, bit pol, bit pulse, int ncyc, string rq);
        int d, bad, ft, fa, fe;
        d = exp_div(code, byp);
        bad = 0; ft = 0; fa = 0; fe = 0;
        bus_wr(4'h0, mk_ctl(0, 0, 0, 0, pol, 0, 0));
        bus_wr(4'h4, {16'(tot_m1), 16'(act)});
        repeat (2) @(negedge clk);
        bus_wr(4'h0, mk_ctl(byp, pulse, pulse, 1, pol, 1, code));
        base = tcnt;
        for (int i = 0; i < ncyc; i++) begin
            int t;
            bit e;
            @(negedge clk);
            t = tcnt - base;
            e = exp_out(t, d, tot_m1 + 1, act, pol, pulse);
            if (pwm_out !== e) begin
                if (bad == 0) begin ft = t; fa = int'(pwm_out); fe = int'(e); end
                bad++;
            end
        end
        check(bad == 0, rq, $sformatf("waveform t=%0d tot=%0d act=%0d div=%0d", ft, tot_m1 + 1, act, d), fa, fe);
    endtask

    // Hold a control setting and confirm the output never leaves the inactive level.
    task automatic idle_hold(logic [31:0] w, bit pol, string rq);
        int bad;
        bad = 0;
        bus_wr(4'h0, w);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pwm_out !== !pol) bad++;
        end
        check(bad == 0, rq, "idle output mismatches", bad, 0);
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int tclr;
        void'($urandom(32'h5A17));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(4'h0, r); check(r == 0, "R1", "ctrl after reset", r, 0);
        bus_rd(4'h4, r); check(r == 0, "R1", "timing after reset", r, 0);
        check(pwm_out === 1'b1, "R1", "output after reset", pwm_out, 1);

        // R2 readback (start bit clear so nothing runs) and R12 idle in pulse mode
        bus_wr(4'h0, 32'hFFFF_FEFF);
        bus_rd(4'h0, r); check(r == 32'h0000_02FF, "R2", "ctrl readback", r, 32'h2FF);
        bus_rd(4'h8, r); check(r == 0, "R2", "unmapped offset", r, 0);
        idle_hold(mk_ctl(1, 0, 1, 1, 1, 1, 0), 1, "R12");

        // R9 load while stopped
        bus_wr(4'h0, 32'h0);
        bus_wr(4'h4, 32'h0003_0002);
        bus_rd(4'h0, r); check(r[28] == 1'b1, "R9", "busy right after write", r[28], 1);
        bus_rd(4'h0, r); check(r[28] == 1'b0, "R9", "busy one cycle later", r[28], 0);
        bus_rd(4'h4, r); check(r == 32'h0003_0002, "R3", "timing readback", r, 32'h0003_0002);

        // R6 gating combinations
        idle_hold(mk_ctl(1, 0, 0, 0, 1, 1, 0), 1, "R6");
        idle_hold(mk_ctl(1, 0, 0, 1, 1, 0, 0), 1, "R6");

        // R4 divisor 120, R3 and R5 in both polarities
        run_wave(1, 1, 0, 0, 1, 0, 500, "R4");
        run_wave(4, 2, 2, 0, 0, 0, 100, "R5");
        run_wave(3, 1, 3, 1, 1, 0, 40, "R4");

        // R11 full and zero duty
        run_wave(3, 6, 1, 0, 1, 0, 40, "R11");
        run_wave(3, 0, 1, 0, 0, 0, 40, "R11");

        // R10 single pulse, then start self-clears
        run_wave(3, 2, 1, 0, 1, 1, 40, "R10");
        bus_rd(4'h0, r); check(r[8] == 1'b0, "R10", "pulse start after pulse", r[8], 0);

        // R7 / R8 update while running: tot 10 div 1, boundary every 10 clocks
        run_wave(9, 3, 0, 1, 1, 0, 15, "R3");
        while (tcnt - base < 20) @(negedge clk);
        bus_wr(4'h4, 32'h0004_0002);
        bus_rd(4'h0, r); check(r[28] == 1'b1, "R7", "busy after running write", r[28], 1);
        bus_wr(4'h4, 32'h0007_0007);
        bus_rd(4'h4, r); check(r == 32'h0004_0002, "R8", "second write ignored", r, 32'h0004_0002);
        tclr = -1;
        for (int k = 0; k < 30; k++) begin
            bus_rd(4'h0, r);
            if (!r[28]) begin tclr = tcnt - base; break; end
        end
        check(tclr == 30, "R7", "busy clear time", tclr, 30);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 40; k++) begin
                int t;
                if (k > 0) @(negedge clk);
                t = tcnt - base - 30;
                if (pwm_out !== exp_out(t, 1, 5, 2, 1, 0)) bad++;
            end
            check(bad == 0, "R7", "waveform after switch-over", bad, 0);
        end

        // Random mixes over R3, R4, R5, R11
        for (int n = 0; n < 10; n++) begin
            int tm, ac, cd, cyc;
            bit by, pl;
            tm = $urandom_range(0, 7);
            ac = $urandom_range(0, 9);
            cd = $urandom_range(0, 3);
            by = 1'($urandom_range(0, 1));
            pl = 1'($urandom_range(0, 1));
            cyc = 2 * (tm + 1) * exp_div(cd, by) + 5;
            run_wave(tm, ac, cd, by, pl, 0, cyc, "R3");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule